// File: doc/BRIEF.md
# 64-Source Prioritised Interrupt Controller

This block collects up to 64 interrupt request lines and presents a single interrupt output to a processor, programmed through a simple 32-bit register port with a one-cycle registered read. Every source has its own configuration word that chooses edge or level detection and holds a 4-bit priority. Sources are masked and unmasked through separate write-one-to-set and write-one-to-clear registers for the lower and upper groups of 32. Because of this, software never has to read, modify and write a shared mask.

The interrupt handler reads a vector register to learn which source to service. Reading that register records the serviced priority, so only a strictly more urgent source can raise the output again. A write to the end-of-interrupt register ends the service period. A vector value of 64 means that nothing is pending, and software treats it as spurious. A soft reset register clears all state. A global generation enable gates the output.

Top module: `intc64_top`

## Requirements
- R1: After a hard reset, all enables, configuration words, the generation enable and the service state are zero, `irq_out` is low and the vector register (0x018) reads 64.
- R2: Writing the set-low (0x008) or set-high (0x00C) register enables each source whose bit is 1. Bit n of set-low is source n, and bit n of set-high is source 32+n. Zero bits leave the other sources unchanged. Reading either set or clear register of a half returns that half's enable mask.
- R3: Writing the clear-low (0x010) or clear-high (0x014) register disables each source whose bit is 1. It uses the same bit mapping as R2, and zero bits leave the other sources unchanged.
- R4: Source n has a read/write configuration word at 0x200 + 8·n. Bit 8 selects edge mode and bits 3:0 hold the priority. All other bits read as zero.
- R5: In level mode a source is pending exactly while its input is high. Pending state reads at 0x020 (sources 0–31) and 0x024 (sources 32–63).
- R6: In edge mode, a rising input sets a pending latch that stays set after the input falls. Writing that source's configuration word with bit 8 clear clears the latch.
- R7: Among the enabled pending sources, the vector register returns the number of the one with the highest priority. On equal priority, the lower source number wins. With none pending, it returns 64.
- R8: `irq_out` stays low while bit 0 of the generation register (0x004) is 0.
- R9: `irq_out` is a register. It goes high one clock after an enabled pending source exists, provided generation is enabled and no service level blocks it.
- R10: A vector read that returns a valid source records that source's priority. After that, `irq_out` asserts only for a strictly higher priority, until any value is written to the end-of-interrupt register (0x01C).
- R11: Writing 0x000 with bit 0 set returns every register to its reset value. Writing it with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_SRC | Interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after `bus_rd` |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
On every cycle, the assertions check the following:
- the generation gate and the one-cycle registered response of the output;
- the effect of set, clear, end-of-interrupt and soft-reset writes on the following cycle;
- that a valid winner is always an enabled pending source;
- that a rising edge in edge mode is latched.

The bench's scenarios alone show the rest:
- the priority order and tie rule across several source patterns;
- the latch holding after the input falls;
- blocking by an equal or lower level after a vector read, and release by a higher level or end-of-interrupt;
- that a soft-reset write without bit 0 set changes nothing.

// File: rtl/intc64_pkg.sv
package intc64_pkg;
  localparam int DATA_W = 32;
  localparam int CFG_EDGE_BIT = 8;

  localparam logic [11:0] A_RESET    = 12'h000;
  localparam logic [11:0] A_GEN      = 12'h004;
  localparam logic [11:0] A_ENSET_LO = 12'h008;
  localparam logic [11:0] A_ENSET_HI = 12'h00C;
  localparam logic [11:0] A_ENCLR_LO = 12'h010;
  localparam logic [11:0] A_ENCLR_HI = 12'h014;
  localparam logic [11:0] A_VEC      = 12'h018;
  localparam logic [11:0] A_EOI      = 12'h01C;
  localparam logic [11:0] A_PEND_LO  = 12'h020;
  localparam logic [11:0] A_PEND_HI  = 12'h024;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RESET, SEL_GEN, SEL_ENSET_LO, SEL_ENSET_HI,
    SEL_ENCLR_LO, SEL_ENCLR_HI, SEL_VEC, SEL_EOI, SEL_PEND_LO,
    SEL_PEND_HI, SEL_CFG
  } reg_sel_e;
endpackage

// File: rtl/intc64_cfg.sv
// Per-source configuration bank: edge-select bit and priority level.
module intc64_cfg #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic                      wr_edge,
  input  logic [PRIO_W-1:0]         wr_prio,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [NUM_SRC-1:0]        edge_mode,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      rd_edge,
  output logic [PRIO_W-1:0]         rd_prio
);
  always_ff @(posedge clk) begin
    if (rst) begin
      edge_mode <= '0;
      prio_flat <= '0;
    end else if (wr_en) begin
      edge_mode[wr_idx] <= wr_edge;
      prio_flat[int'(wr_idx)*PRIO_W +: PRIO_W] <= wr_prio;
    end
  end

  assign rd_edge = edge_mode[rd_idx];
  assign rd_prio = prio_flat[int'(rd_idx)*PRIO_W +: PRIO_W];
endmodule

// File: rtl/intc64_pend.sv
// Per-source pending logic: level pass-through or latched rising edge.
module intc64_pend #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic [NUM_SRC-1:0] edge_mode,
  output logic [NUM_SRC-1:0] pending
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic prev_q;
    logic latch_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        prev_q <= irq_src[g];
        if (!edge_mode[g])
          latch_q <= 1'b0;
        else if (irq_src[g] && !prev_q)
          latch_q <= 1'b1;
      end
    end
    assign pending[g] = edge_mode[g] ? latch_q : irq_src[g];
  end
endmodule

// File: rtl/intc64_arb.sv
// Priority selection: highest level wins, lowest index on a tie.
module intc64_arb #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 4,
  localparam int ID_W   = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0]        req,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      win_valid,
  output logic [ID_W-1:0]           win_id,
  output logic [PRIO_W-1:0]         win_prio
);
  always_comb begin
    win_valid = 1'b0;
    win_id    = ID_W'(NUM_SRC);
    win_prio  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && (!win_valid || prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        win_prio  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/intc64_top.sv
module intc64_top
  import intc64_pkg::*;
#(
  parameter int NUM_SRC  = 64,
  parameter int PRIO_W   = 4,
  parameter int ADDR_W   = 12,
  parameter int CFG_BASE = 512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_out
);
  localparam int ID_W  = $clog2(NUM_SRC + 1);
  localparam int IDX_W = $clog2(NUM_SRC);

  reg_sel_e            sel;
  logic [ADDR_W-1:0]   cfg_off;
  logic [IDX_W-1:0]    cfg_idx;
  logic                soft_rst, st_rst;
  logic                gen_en;
  logic [NUM_SRC-1:0]  en, pending, req, edge_mode;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic                rd_edge;
  logic [PRIO_W-1:0]   rd_prio;
  logic                win_valid;
  logic [ID_W-1:0]     win_id;
  logic [PRIO_W-1:0]   win_prio;
  logic                active;
  logic [PRIO_W-1:0]   act_lvl;
  logic [63:0]         set_mask, clr_mask, en_w, pend_w;
  logic                irq_q;
  logic [31:0]         rdata_q;

  // Address decode
  assign cfg_off = bus_addr - ADDR_W'(CFG_BASE);
  assign cfg_idx = cfg_off[IDX_W+2:3];

  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == ADDR_W'(A_RESET))    sel = SEL_RESET;
    else if (bus_addr == ADDR_W'(A_GEN))      sel = SEL_GEN;
    else if (bus_addr == ADDR_W'(A_ENSET_LO)) sel = SEL_ENSET_LO;
    else if (bus_addr == ADDR_W'(A_ENSET_HI)) sel = SEL_ENSET_HI;
    else if (bus_addr == ADDR_W'(A_ENCLR_LO)) sel = SEL_ENCLR_LO;
    else if (bus_addr == ADDR_W'(A_ENCLR_HI)) sel = SEL_ENCLR_HI;
    else if (bus_addr == ADDR_W'(A_VEC))      sel = SEL_VEC;
    else if (bus_addr == ADDR_W'(A_EOI))      sel = SEL_EOI;
    else if (bus_addr == ADDR_W'(A_PEND_LO))  sel = SEL_PEND_LO;
    else if (bus_addr == ADDR_W'(A_PEND_HI))  sel = SEL_PEND_HI;
    else if (bus_addr >= ADDR_W'(CFG_BASE) && cfg_off[2:0] == 3'b000 &&
             (cfg_off >> 3) < ADDR_W'(NUM_SRC))
      sel = SEL_CFG;
  end

  // Soft reset folds into the synchronous reset of all state
  assign soft_rst = bus_wr && (sel == SEL_RESET) && bus_wdata[0];
  assign st_rst   = rst || soft_rst;

  // Global generation enable
  always_ff @(posedge clk) begin
    if (st_rst)                          gen_en <= 1'b0;
    else if (bus_wr && sel == SEL_GEN)   gen_en <= bus_wdata[0];
  end

  // Enable mask: write-one-to-set / write-one-to-clear halves
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (bus_wr) begin
      case (sel)
        SEL_ENSET_LO: set_mask = {32'b0, bus_wdata};
        SEL_ENSET_HI: set_mask = {bus_wdata, 32'b0};
        SEL_ENCLR_LO: clr_mask = {32'b0, bus_wdata};
        SEL_ENCLR_HI: clr_mask = {bus_wdata, 32'b0};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st_rst) en <= '0;
    else        en <= (en | set_mask[NUM_SRC-1:0]) & ~clr_mask[NUM_SRC-1:0];
  end

  intc64_cfg #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) cfg_i (
    .clk       (clk),
    .rst       (st_rst),
    .wr_en     (bus_wr && sel == SEL_CFG),
    .wr_idx    (cfg_idx),
    .wr_edge   (bus_wdata[CFG_EDGE_BIT]),
    .wr_prio   (bus_wdata[PRIO_W-1:0]),
    .rd_idx    (cfg_idx),
    .edge_mode (edge_mode),
    .prio_flat (prio_flat),
    .rd_edge   (rd_edge),
    .rd_prio   (rd_prio)
  );

  intc64_pend #(.NUM_SRC(NUM_SRC)) pend_i (
    .clk       (clk),
    .rst       (st_rst),
    .irq_src   (irq_src),
    .edge_mode (edge_mode),
    .pending   (pending)
  );

  assign req = pending & en;

  intc64_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) arb_i (
    .req       (req),
    .prio_flat (prio_flat),
    .win_valid (win_valid),
    .win_id    (win_id),
    .win_prio  (win_prio)
  );

  // Service level: recorded on a valid vector read, released by EOI
  always_ff @(posedge clk) begin
    if (st_rst) begin
      active  <= 1'b0;
      act_lvl <= '0;
    end else if (bus_wr && sel == SEL_EOI) begin
      active  <= 1'b0;
    end else if (bus_rd && sel == SEL_VEC && win_valid) begin
      active  <= 1'b1;
      act_lvl <= win_prio;
    end
  end

  // Registered interrupt output
  always_ff @(posedge clk) begin
    if (st_rst) irq_q <= 1'b0;
    else        irq_q <= gen_en && win_valid && (!active || win_prio > act_lvl);
  end
  assign irq_out = irq_q;

  // Registered read data
  assign en_w   = 64'(en);
  assign pend_w = 64'(pending);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (sel)
        SEL_GEN:                    rdata_q <= {31'b0, gen_en};
        SEL_ENSET_LO, SEL_ENCLR_LO: rdata_q <= en_w[31:0];
        SEL_ENSET_HI, SEL_ENCLR_HI: rdata_q <= en_w[63:32];
        SEL_VEC:                    rdata_q <= 32'(win_id);
        SEL_PEND_LO:                rdata_q <= pend_w[31:0];
        SEL_PEND_HI:                rdata_q <= pend_w[63:32];
        SEL_CFG: begin
          rdata_q <= '0;
          rdata_q[CFG_EDGE_BIT]  <= rd_edge;
          rdata_q[PRIO_W-1:0]    <= rd_prio;
        end
        default:                    rdata_q <= '0;
      endcase
    end
  end
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/intc64_chk.sv
module intc64_chk
  import intc64_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 12,
  parameter int ID_W    = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               wdata_b0,
  input logic [NUM_SRC-1:0] irq_src,
  input logic               irq_out,
  input logic               gen_en,
  input logic [NUM_SRC-1:0] en,
  input logic [NUM_SRC-1:0] req,
  input logic [NUM_SRC-1:0] pending,
  input logic [NUM_SRC-1:0] edge_mode,
  input logic               active,
  input logic               win_valid,
  input logic [ID_W-1:0]    win_id
);
  localparam int IDX_W = $clog2(NUM_SRC);
  logic soft_w;
  assign soft_w = bus_wr && bus_addr == ADDR_W'(A_RESET) && wdata_b0;

  assert_gen_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !gen_en |=> !irq_out);

  assert_out_rise_R9: assert property (@(posedge clk) disable iff (rst)
    (gen_en && win_valid && !active && !soft_w) |=> irq_out);

  assert_out_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |=> !irq_out);

  assert_winner_R7: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> req[win_id[IDX_W-1:0]]);

  assert_set_lo_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(A_ENSET_LO) && wdata_b0) |=> en[0]);

  assert_clr_lo_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(A_ENCLR_LO) && wdata_b0) |=> !en[0]);

  assert_edge_latch_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_src[0]) && edge_mode[0] && !bus_wr) |=> pending[0]);

  assert_eoi_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(A_EOI)) |=> !active);

  assert_soft_rst_R11: assert property (@(posedge clk) disable iff (rst)
    soft_w |=> (en == '0 && !gen_en && !irq_out && !active));
endmodule

bind intc64_top intc64_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ID_W(ID_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .wdata_b0  (bus_wdata[0]),
  .irq_src   (irq_src),
  .irq_out   (irq_out),
  .gen_en    (gen_en),
  .en        (en),
  .req       (req),
  .pending   (pending),
  .edge_mode (edge_mode),
  .active    (active),
  .win_valid (win_valid),
  .win_id    (win_id)
);

// File: tb/intc64_top_tb_top.sv
module intc64_top_tb_top;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_SLO = 3'd2,
                         OP_SHI = 3'd3, OP_IRQ = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 58;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,  12'h004, 32'h0,        32'h0,        8'd1},  // R1 gen off
    '{OP_RD,  12'h018, 32'h0,        32'd64,       8'd1},  // R1 vector empty
    '{OP_IRQ, 12'h000, 32'h0,        32'h0,        8'd1},  // R1 output low
    '{OP_WR,  12'h008, 32'h5,        32'h0,        8'd2},
    '{OP_RD,  12'h008, 32'h0,        32'h5,        8'd2},  // R2
    '{OP_WR,  12'h008, 32'h10,       32'h0,        8'd2},
    '{OP_RD,  12'h010, 32'h0,        32'h15,       8'd2},  // R2 zeros keep
    '{OP_WR,  12'h010, 32'h4,        32'h0,        8'd3},
    '{OP_RD,  12'h008, 32'h0,        32'h11,       8'd3},  // R3
    '{OP_WR,  12'h00C, 32'h80000001, 32'h0,        8'd2},
    '{OP_RD,  12'h00C, 32'h0,        32'h80000001, 8'd2},  // R2 high half
    '{OP_WR,  12'h220, 32'hFFFF0E05, 32'h0,        8'd4},
    '{OP_RD,  12'h220, 32'h0,        32'h005,      8'd4},  // R4 level prio5
    '{OP_WR,  12'h300, 32'h107,      32'h0,        8'd4},
    '{OP_RD,  12'h300, 32'h0,        32'h107,      8'd4},  // R4 edge prio7
    '{OP_SLO, 12'h000, 32'h11,       32'h0,        8'd5},
    '{OP_RD,  12'h020, 32'h0,        32'h11,       8'd5},  // R5
    '{OP_RD,  12'h018, 32'h0,        32'd4,        8'd7},  // R7 prio5 > prio0
    '{OP_WR,  12'h01C, 32'h0,        32'h0,        8'd10},
    '{OP_IRQ, 12'h000, 32'h0,        32'h0,        8'd8},  // R8 gated
    '{OP_WR,  12'h004, 32'h1,        32'h0,        8'd8},
    '{OP_IRQ, 12'h000, 32'h0,        32'h1,        8'd9},  // R9
    '{OP_SHI, 12'h000, 32'h1,        32'h0,        8'd6},
    '{OP_SHI, 12'h000, 32'h0,        32'h0,        8'd6},
    '{OP_RD,  12'h024, 32'h0,        32'h1,        8'd6},  // R6 latch held
    '{OP_RD,  12'h018, 32'h0,        32'd32,       8'd7},  // R7
    '{OP_IRQ, 12'h000, 32'h0,        32'h0,        8'd10}, // R10 equal blocked
    '{OP_WR,  12'h3F8, 32'h00F,      32'h0,        8'd4},
    '{OP_SHI, 12'h000, 32'h80000000, 32'h0,        8'd5},
    '{OP_IRQ, 12'h000, 32'h0,        32'h1,        8'd10}, // R10 higher wins
    '{OP_RD,  12'h018, 32'h0,        32'd63,       8'd7},  // R7
    '{OP_SHI, 12'h000, 32'h0,        32'h0,        8'd5},
    '{OP_IRQ, 12'h000, 32'h0,        32'h0,        8'd10}, // R10 lower blocked
    '{OP_WR,  12'h01C, 32'hDEAD,     32'h0,        8'd10},
    '{OP_IRQ, 12'h000, 32'h0,        32'h1,        8'd10}, // R10 released
    '{OP_WR,  12'h300, 32'h007,      32'h0,        8'd6},
    '{OP_RD,  12'h024, 32'h0,        32'h0,        8'd6},  // R6 latch cleared
    '{OP_RD,  12'h018, 32'h0,        32'd4,        8'd7},  // R7
    '{OP_WR,  12'h01C, 32'h0,        32'h0,        8'd10},
    '{OP_WR,  12'h200, 32'h005,      32'h0,        8'd7},
    '{OP_RD,  12'h018, 32'h0,        32'd0,        8'd7},  // R7 tie -> lower
    '{OP_WR,  12'h01C, 32'h0,        32'h0,        8'd10},
    '{OP_WR,  12'h00C, 32'h3,        32'h0,        8'd2},
    '{OP_WR,  12'h014, 32'h1,        32'h0,        8'd3},
    '{OP_RD,  12'h00C, 32'h0,        32'h80000002, 8'd3},  // R3 high half
    '{OP_WR,  12'h000, 32'hFFFFFFFE, 32'h0,        8'd11},
    '{OP_RD,  12'h004, 32'h0,        32'h1,        8'd11}, // R11 no effect
    '{OP_RD,  12'h008, 32'h0,        32'h11,       8'd11}, // R11 no effect
    '{OP_WR,  12'h000, 32'h1,        32'h0,        8'd11},
    '{OP_RD,  12'h004, 32'h0,        32'h0,        8'd11}, // R11
    '{OP_RD,  12'h008, 32'h0,        32'h0,        8'd11}, // R11
    '{OP_RD,  12'h00C, 32'h0,        32'h0,        8'd11}, // R11
    '{OP_RD,  12'h200, 32'h0,        32'h0,        8'd11}, // R11
    '{OP_RD,  12'h300, 32'h0,        32'h0,        8'd11}, // R11
    '{OP_IRQ, 12'h000, 32'h0,        32'h0,        8'd11}, // R11
    '{OP_RD,  12'h018, 32'h0,        32'd64,       8'd11}, // R11
    '{OP_RD,  12'h020, 32'h0,        32'h11,       8'd5},  // R5 after reset
    '{OP_RD,  12'h3F8, 32'h0,        32'h0,        8'd11}  // R11
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_src = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  intc64_top dut_i (
    .clk(clk), .rst(rst), .irq_src(irq_src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    settle();
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    settle();
  endtask

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("vec %0d R%0d", i, VECS[i].req);
      case (VECS[i].op)
        OP_WR:  bus_write(VECS[i].addr, VECS[i].data);
        OP_RD:  begin bus_read(VECS[i].addr, rv); check(tag, rv, VECS[i].exp); end
        OP_SLO: begin irq_src[31:0] = VECS[i].data; settle(); end
        OP_SHI: begin irq_src[63:32] = VECS[i].data; settle(); end
        default: check(tag, {31'b0, irq_out}, VECS[i].exp);
      endcase
    end

    // Directed: hard reset mid-run clears everything (R1)
    bus_write(12'h008, 32'hFFFFFFFF);
    bus_write(12'h004, 32'h1);
    check("R1 pre-reset irq", {31'b0, irq_out}, 32'h1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    settle();
    check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
    bus_read(12'h008, rv); check("R1 enables after reset", rv, 32'h0);
    bus_read(12'h004, rv); check("R1 gen after reset", rv, 32'h0);
    bus_read(12'h018, rv); check("R1 vector after reset", rv, 32'd64);

    // Directed: edge source set up while input high does not latch (R6)
    irq_src = '0;
    irq_src[40] = 1'b1;
    settle();
    bus_write(12'h340, 32'h101);
    bus_read(12'h024, rv); check("R6 no edge while held", rv, 32'h0);
    irq_src[40] = 1'b0; settle();
    irq_src[40] = 1'b1; settle();
    irq_src[40] = 1'b0; settle();
    bus_read(12'h024, rv); check("R6 edge latched", rv, 32'h100);
    bus_write(12'h00C, 32'h100);
    bus_write(12'h004, 32'h1);
    check("R9 edge source drives output", {31'b0, irq_out}, 32'h1);
    bus_read(12'h018, rv); check("R7 edge source vector", rv, 32'd40);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule